// File: doc/BRIEF.md
# Two-Bit Counter Branch Direction Predictor

This block holds a table of two-bit counters, one per entry, and predicts whether a conditional branch will be taken. At fetch the lookup address selects one counter, and the upper bit of that counter is returned as the prediction in the same cycle. When a branch resolves, the resolving address and the actual outcome are presented, and the selected counter is rewritten at the next clock edge.

The entry index is taken from the address bits just above the two word-alignment bits. With the default of six index bits, address bits [7:2] select one of 64 entries. The two alignment bits and every bit above the index field do not take part in the selection. A static mode input chooses between two update policies. In the first, the counter saturates upward on a taken outcome and downward on a not-taken outcome. In the second, a miss from a weak state jumps to the strong state of the other direction, so the predicted direction flips only after two consecutive misses. Target prediction and history-based indexing are not part of this block.

Top module: `bpredTable`

## Requirements
- R1: After reset every counter holds 2'b10 (weakly taken), so every lookup predicts taken.
- R2: The entry index is address bits [IDX_BITS+1:2]. Address bits [1:0] and all bits above bit IDX_BITS+1 have no effect on which entry is read or written.
- R3: predTaken equals bit 1 of the counter selected by lookupPc. The counter encoding is 2'b11 strong taken, 2'b10 weak taken, 2'b01 weak not-taken and 2'b00 strong not-taken.
- R4: With hystMode=0, a taken outcome moves the counter up by one and saturates at 2'b11.
- R5: With hystMode=0, a not-taken outcome moves the counter down by one and saturates at 2'b00.
- R6: With hystMode=1, 2'b10 followed by not-taken goes to 2'b00, and 2'b01 followed by taken goes to 2'b11.
- R7: With hystMode=1, a miss from a strong state goes to the weak state of the same direction (2'b11 to 2'b10, 2'b00 to 2'b01), and a correct outcome leaves the counter strong in that direction.
- R8: While updValid is 0, no counter changes, whatever values updPc and updTaken hold.
- R9: An update changes only the addressed entry. A lookup of that entry in the same cycle as the update returns the old value, and the new value is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hystMode | input | 1 | 0: plain saturating update, 1: update with hysteresis |
| lookupPc | input | PC_W | Address of the branch being fetched |
| predTaken | output | 1 | Prediction for lookupPc, 1 means taken |
| updValid | input | 1 | A resolved branch outcome is present |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome of the resolved branch, 1 means taken |

## Verification
The bench builds the block with IDX_BITS=4 and PC_W=32, which gives a 16-entry table. A few thousand random updates then visit every counter in every state many times under both policies. The small index field also means that random addresses often differ only above bit 5 or in bits [1:0], so aliasing onto the same entry occurs all the time. Because the full counter state is visible only through its upper bit, directed sequences drive each counter through chains of outcomes that set the plain and hysteresis policies apart one step later.

// File: rtl/bpredPkg.sv
package bpredPkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctrState_t;

  localparam ctrState_t CTR_RESET = CTR_WT;

  typedef struct packed {
    logic      wrEn;
    ctrState_t wrVal;
  } ctrlStrb_t;

endpackage

// File: rtl/bpredCtrl.sv
module bpredCtrl
  import bpredPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hystMode,
  input  logic      updValid,
  input  logic      updTaken,
  input  ctrState_t updCtr,
  output ctrlStrb_t strb
);

  ctrState_t nxtCtr;

  always_comb begin
    nxtCtr = updCtr;
    if (!hystMode) begin
      unique case (updCtr)
        CTR_SNT: nxtCtr = updTaken ? CTR_WNT : CTR_SNT;
        CTR_WNT: nxtCtr = updTaken ? CTR_WT  : CTR_SNT;
        CTR_WT:  nxtCtr = updTaken ? CTR_ST  : CTR_WNT;
        CTR_ST:  nxtCtr = updTaken ? CTR_ST  : CTR_WT;
        default: nxtCtr = updCtr;
      endcase
    end else begin
      unique case (updCtr)
        CTR_SNT: nxtCtr = updTaken ? CTR_WNT : CTR_SNT;
        CTR_WNT: nxtCtr = updTaken ? CTR_ST  : CTR_SNT;
        CTR_WT:  nxtCtr = updTaken ? CTR_ST  : CTR_SNT;
        CTR_ST:  nxtCtr = updTaken ? CTR_ST  : CTR_WT;
        default: nxtCtr = updCtr;
      endcase
    end
  end

  assign strb.wrEn  = updValid;
  assign strb.wrVal = nxtCtr;

  p_plain_sat_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !hystMode && updTaken && updCtr == CTR_ST) |-> (strb.wrVal == CTR_ST));

  p_plain_sat_lo_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !hystMode && !updTaken && updCtr == CTR_SNT) |-> (strb.wrVal == CTR_SNT));

  p_hyst_cross_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && hystMode && !updTaken && updCtr == CTR_WT) |-> (strb.wrVal == CTR_SNT));

  p_hyst_strong_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && hystMode && !updTaken && updCtr == CTR_ST) |-> (strb.wrVal == CTR_WT));

  p_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !strb.wrEn);

endmodule

// File: rtl/bpredStore.sv
module bpredStore
  import bpredPkg::*;
#(
  parameter int IDX_BITS = 6,
  parameter int PC_W     = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  input  logic [PC_W-1:0] updPc,
  input  ctrlStrb_t       strb,
  output logic            predTaken,
  output ctrState_t       updCtr
);

  localparam int DEPTH  = 1 << IDX_BITS;
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_BITS - 1;

  ctrState_t ctrMem [DEPTH];

  logic [IDX_BITS-1:0] lookIdx;
  logic [IDX_BITS-1:0] updIdx;

  assign lookIdx = lookupPc[IDX_HI:IDX_LO];
  assign updIdx  = updPc[IDX_HI:IDX_LO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ctrMem[i] <= CTR_RESET;
    end else if (strb.wrEn) begin
      ctrMem[updIdx] <= strb.wrVal;
    end
  end

  assign predTaken = ctrMem[lookIdx][1];
  assign updCtr    = ctrMem[updIdx];

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (ctrMem[$past(updIdx)] == $past(strb.wrVal)));

endmodule

// File: rtl/bpredTable.sv
module bpredTable
  import bpredPkg::*;
#(
  parameter int IDX_BITS = 6,
  parameter int PC_W     = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hystMode,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  ctrlStrb_t strb;
  ctrState_t updCtr;

  bpredCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .hystMode (hystMode),
    .updValid (updValid),
    .updTaken (updTaken),
    .updCtr   (updCtr),
    .strb     (strb)
  );

  bpredStore #(
    .IDX_BITS (IDX_BITS),
    .PC_W     (PC_W)
  ) store_i (
    .clk       (clk),
    .rstN      (rstN),
    .lookupPc  (lookupPc),
    .updPc     (updPc),
    .strb      (strb),
    .predTaken (predTaken),
    .updCtr    (updCtr)
  );

endmodule

// File: tb/bpredTable_tb_top.sv
`timescale 1ns/1ps
module bpredTable_tb_top;

  localparam int IB   = 4;
  localparam int PW   = 32;
  localparam int NENT = 1 << IB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hystMode = 1'b0;
  logic [PW-1:0] lookupPc = '0;
  logic          predTaken;
  logic          updValid = 1'b0;
  logic [PW-1:0] updPc = '0;
  logic          updTaken = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [1:0] mdl [NENT];

  always #5 clk = ~clk;

  bpredTable #(.IDX_BITS(IB), .PC_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .hystMode(hystMode), .lookupPc(lookupPc),
    .predTaken(predTaken), .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic int idxOf(logic [PW-1:0] pc);
    return int'((pc >> 2) & (NENT - 1));
  endfunction

  function automatic logic [1:0] nextCtr(logic [1:0] cur, logic tk, logic hy);
    logic hit;
    if (!hy) begin
      if (tk) return (cur == 2'd3) ? 2'd3 : cur + 2'd1;
      return (cur == 2'd0) ? 2'd0 : cur - 2'd1;
    end
    hit = (cur[1] == tk);
    if (hit) return tk ? 2'b11 : 2'b00;
    if (cur == 2'b11 || cur == 2'b00) return {cur[1], ~cur[1]};
    return tk ? 2'b11 : 2'b00;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: predTaken=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check the lookup before the edge, apply the update after it.
  task automatic step(string tag, logic [PW-1:0] lpc, logic v, logic [PW-1:0] upc, logic tk);
    @(negedge clk);
    lookupPc = lpc; updValid = v; updPc = upc; updTaken = tk;
    #1;
    check(tag, predTaken, mdl[idxOf(lpc)][1]);
    @(posedge clk);
    if (v) mdl[idxOf(upc)] = nextCtr(mdl[idxOf(upc)], tk, hystMode);
  endtask

  task automatic look(string tag, logic [PW-1:0] lpc, logic exp);
    @(negedge clk);
    lookupPc = lpc; updValid = 1'b0;
    #1;
    check(tag, predTaken, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; updValid = 1'b0;
    for (int i = 0; i < NENT; i++) mdl[i] = 2'b10;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    doReset();
    // R1: every entry predicts taken after reset
    for (int i = 0; i < NENT; i++) look("R1 reset", PW'(i * 4), 1'b1);

    // R4/R5 plain mode: two not-taken drops to 00, saturate, then climb
    hystMode = 1'b0;
    step("R5", 32'h10, 1, 32'h10, 0);   // 10 -> 01
    look("R5 weak nt", 32'h10, 1'b0);
    step("R5", 32'h10, 1, 32'h10, 0);   // 01 -> 00
    step("R5", 32'h10, 1, 32'h10, 0);   // stays 00
    step("R4", 32'h10, 1, 32'h10, 1);   // 00 -> 01
    look("R5 saturated low", 32'h10, 1'b0);
    step("R4", 32'h10, 1, 32'h10, 1);   // 01 -> 10
    look("R4 climb", 32'h10, 1'b1);
    step("R4", 32'h10, 1, 32'h10, 1);   // 11
    step("R4", 32'h10, 1, 32'h10, 1);   // stays 11
    step("R4", 32'h10, 1, 32'h10, 0);   // 10
    look("R4 saturated high", 32'h10, 1'b1);

    // R6/R7 hysteresis mode
    doReset();
    hystMode = 1'b1;
    step("R6", 32'h20, 1, 32'h20, 0);   // 10 -> 00
    step("R6", 32'h20, 1, 32'h20, 1);   // 00 -> 01
    look("R6 weak nt from strong", 32'h20, 1'b0);
    step("R6", 32'h20, 1, 32'h20, 1);   // 01 -> 11
    step("R7", 32'h20, 1, 32'h20, 0);   // 11 -> 10
    look("R7 strong miss keeps taken", 32'h20, 1'b1);
    step("R7", 32'h20, 1, 32'h20, 1);   // 10 -> 11
    step("R7", 32'h20, 1, 32'h20, 0);   // 11 -> 10
    look("R7 hit restores strong", 32'h20, 1'b1);

    // R2: bits [1:0] and high bits ignored in indexing
    doReset();
    hystMode = 1'b0;
    step("R2", 32'h0, 1, 32'hFFFF_FF07, 0);  // entry 1 -> 01
    look("R2 alias low bits", 32'h0000_0004, 1'b0);
    look("R2 alias high bits", 32'h1234_5647, 1'b0);
    look("R2 neighbour untouched", 32'h0000_0008, 1'b1);

    // R8: no change while updValid is low
    for (int i = 0; i < 4; i++) step("R8", 32'h0, 0, 32'h4, 0);
    look("R8 entry unchanged", 32'h4, 1'b0);
    look("R8 other unchanged", 32'hC, 1'b1);

    // R9: same-cycle read returns old value, next cycle new value
    step("R9 same cycle old", 32'h4, 1, 32'h4, 1);  // entry 1: 01 -> 10
    look("R9 next cycle new", 32'h4, 1'b1);

    // R3/R4..R7 random mix against the model
    for (int m = 0; m < 2; m++) begin
      doReset();
      hystMode = m[0];
      for (int n = 0; n < 3000; n++) begin
        logic [PW-1:0] lp, up;
        lp = $urandom; up = $urandom;
        if ($urandom_range(3) == 0) lp = up;
        step("R3 random", lp, ($urandom_range(4) != 0), up, $urandom_range(1) == 1);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule